// File: doc/BRIEF.md
# Task Admission Gateway Router

This block sits at the entrance of a hardware task scheduler. Worker threads hand it two kinds of messages on two separate input channels: submissions of new tasks and notices that a task has finished. A submission is a header beat (task identifier and dependency count) followed by one beat per dependency (address and access direction). The block claims a free slot from a queue that the task stations keep filled, sends one header packet to that station, and then sends one packet per routed dependency to a dependency tracker picked by hashing the dependency address.

Finish notices never wait behind submissions. They go through their own one-register path and are forwarded, unchanged, to the station and slot they name. When no free slot is on offer, the pending submission stays parked inside the block while finish notices keep flowing, so the block itself never holds back a completion. Every port uses a valid/ready handshake, and every output packet holds still until it is taken.

Top module: `tsk_admit_gw`

## Requirements
- R1: During and right after the synchronous active-high reset, hd_valid, dp_valid and fo_valid are low, nt_ready and cm_ready are high, and fs_ready and dep_ready are low.
- R2: After a submission header is taken and then one free-slot entry is popped, exactly one header packet follows, carrying the submitted task identifier and dependency count together with the station and slot of that free-slot entry; hd_valid rises on the cycle after the pop.
- R3: A free-slot entry is popped only while a taken submission is waiting for a slot (fs_ready is low at all other times), and exactly one is popped per submission; while none is offered, hd_valid stays low.
- R4: Each routed dependency packet carries the beat's address and direction, the station and slot of its task, and its 0-based position within the task, where positions count every dependency beat, routed or not. Packets leave in beat order.
- R5: With the default parameters the tracker index is the XOR of the sixteen 2-bit fields of addr[31:3] zero-extended to 32 bits (field k is bits 2k+1..2k of that value).
- R6: Direction codes are 00 input, 01 output, 10 inout, 11 direct value. A beat with code 11 is consumed but produces no tracker packet; dp_dir is never 11.
- R7: A finish notice taken on a clock edge appears on the fo outputs on the next cycle with its station and slot unchanged, and notices leave in arrival order.
- R8: cm_ready is high whenever the fo output is empty or is being taken, regardless of the state of submission handling, including while a submission is parked.
- R9: While hd_valid, dp_valid or fo_valid is high and the matching ready is low, the valid stays high and all fields of that packet stay unchanged.
- R10: A submission with a dependency count of zero yields a header packet only, after which nt_ready returns high.
- R11: nt_ready is low from the cycle after a submission header is taken until its header packet and all its dependency beats are handled; at most one of nt_ready, fs_ready and dep_ready is high in any cycle.
- R12: dep_ready is high only while a submission is in its dependency phase, with its header packet already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nt_valid | input | 1 | Submission header offered |
| nt_ready | output | 1 | Submission header taken |
| nt_task_id | input | 16 | Task identifier |
| nt_dep_count | input | 4 | Number of dependency beats that follow (0 to 15) |
| dep_valid | input | 1 | Dependency beat offered |
| dep_ready | output | 1 | Dependency beat taken |
| dep_addr | input | 32 | Dependency address |
| dep_dir | input | 2 | Direction code (00 in, 01 out, 10 inout, 11 direct) |
| fs_valid | input | 1 | Free-slot entry offered by the stations |
| fs_ready | output | 1 | Free-slot entry popped |
| fs_station | input | 2 | Station owning the free slot |
| fs_slot | input | 8 | Free slot index |
| hd_valid | output | 1 | Header packet valid |
| hd_ready | input | 1 | Header packet taken |
| hd_station | output | 2 | Destination station |
| hd_slot | output | 8 | Slot in that station |
| hd_task_id | output | 16 | Task identifier |
| hd_dep_count | output | 4 | Dependency count |
| dp_valid | output | 1 | Tracker packet valid |
| dp_ready | input | 1 | Tracker packet taken |
| dp_tracker | output | 2 | Destination tracker (address hash) |
| dp_addr | output | 32 | Dependency address |
| dp_dir | output | 2 | Direction code |
| dp_station | output | 2 | Station holding the task |
| dp_slot | output | 8 | Slot holding the task |
| dp_index | output | 4 | Position of the dependency in the task |
| cm_valid | input | 1 | Finish notice offered |
| cm_ready | output | 1 | Finish notice taken |
| cm_station | input | 2 | Station named by the notice |
| cm_slot | input | 8 | Slot named by the notice |
| fo_valid | output | 1 | Forwarded finish notice valid |
| fo_ready | input | 1 | Forwarded finish notice taken |
| fo_station | output | 2 | Station of the forwarded notice |
| fo_slot | output | 8 | Slot of the forwarded notice |

## Verification
The bench withholds free slots while a submission waits and pushes a burst of finish notices through; a gateway that coupled the two paths would stop taking notices or lose them. It sends tasks with no dependencies and tasks made only of direct values, where a wrong count would hang the dependency phase or emit packets that should not exist, and it checks that positions still count skipped direct beats. Random back-pressure on every output catches packets that change or vanish before they are taken, and random addresses exercise every bit of the hash so a fold that dropped or misaligned a field shows up as a wrong tracker index.

// File: rtl/gw_pkg.sv
package gw_pkg;

  // Access direction of one dependency beat.
  typedef enum logic [1:0] {
    DIR_IN     = 2'b00,
    DIR_OUT    = 2'b01,
    DIR_INOUT  = 2'b10,
    DIR_DIRECT = 2'b11
  } dep_dir_e;

  // Phases of admitting one submission.
  typedef enum logic [2:0] {
    ADM_IDLE,
    ADM_WAIT_SLOT,
    ADM_SEND_HDR,
    ADM_READ_DEP,
    ADM_SEND_DEP
  } adm_state_e;

endpackage

// File: rtl/gw_dep_hash.sv
module gw_dep_hash #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3,
  parameter int TRK_W      = 2,
  parameter bit FOLD_XOR   = 1'b1
) (
  input  logic [ADDR_W-ALIGN_BITS-1:0] key,
  output logic [TRK_W-1:0]             trk
);

  localparam int SRC_W  = ADDR_W - ALIGN_BITS;
  localparam int CHUNKS = (SRC_W + TRK_W - 1) / TRK_W;
  localparam int PAD_W  = CHUNKS * TRK_W;

  logic [PAD_W-1:0] padded;

  always_comb begin
    padded            = '0;
    padded[SRC_W-1:0] = key;
  end

  generate
    if (FOLD_XOR) begin : g_xor_fold
      // Every field of the line address flips the index.
      always_comb begin
        trk = '0;
        for (int i = 0; i < CHUNKS; i++) begin
          trk = trk ^ padded[i*TRK_W +: TRK_W];
        end
      end
    end else begin : g_sum_fold
      // Modular sum of the fields: carries mix neighbouring fields.
      always_comb begin
        trk = '0;
        for (int i = 0; i < CHUNKS; i++) begin
          trk = trk + padded[i*TRK_W +: TRK_W];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gw_cmpl_path.sv
module gw_cmpl_path #(
  parameter int STN_W  = 2,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cm_valid,
  output logic              cm_ready,
  input  logic [STN_W-1:0]  cm_station,
  input  logic [SLOT_W-1:0] cm_slot,
  output logic              fo_valid,
  input  logic              fo_ready,
  output logic [STN_W-1:0]  fo_station,
  output logic [SLOT_W-1:0] fo_slot
);

  logic take;

  // The register can be refilled on the same edge it empties.
  assign cm_ready = !fo_valid || fo_ready;
  assign take     = cm_valid && cm_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      fo_valid <= 1'b0;
    end else if (take) begin
      fo_valid <= 1'b1;
    end else if (fo_ready) begin
      fo_valid <= 1'b0;
    end
  end

  // Payload has no reset: it is only read when fo_valid is high.
  always_ff @(posedge clk) begin
    if (take) begin
      fo_station <= cm_station;
      fo_slot    <= cm_slot;
    end
  end

endmodule

// File: rtl/gw_admit_fsm.sv
module gw_admit_fsm
  import gw_pkg::*;
#(
  parameter int TID_W  = 16,
  parameter int CNT_W  = 4,
  parameter int STN_W  = 2,
  parameter int SLOT_W = 8,
  parameter int ADDR_W = 32,
  parameter int TRK_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  // submission header
  input  logic              nt_valid,
  output logic              nt_ready,
  input  logic [TID_W-1:0]  nt_task_id,
  input  logic [CNT_W-1:0]  nt_dep_count,
  // dependency beats, with the hashed tracker index alongside
  input  logic              dep_valid,
  output logic              dep_ready,
  input  logic [ADDR_W-1:0] dep_addr,
  input  logic [1:0]        dep_dir,
  input  logic [TRK_W-1:0]  dep_trk,
  // free-slot queue
  input  logic              fs_valid,
  output logic              fs_ready,
  input  logic [STN_W-1:0]  fs_station,
  input  logic [SLOT_W-1:0] fs_slot,
  // header packet
  output logic              hd_valid,
  input  logic              hd_ready,
  output logic [STN_W-1:0]  hd_station,
  output logic [SLOT_W-1:0] hd_slot,
  output logic [TID_W-1:0]  hd_task_id,
  output logic [CNT_W-1:0]  hd_dep_count,
  // tracker packet
  output logic              dp_valid,
  input  logic              dp_ready,
  output logic [TRK_W-1:0]  dp_tracker,
  output logic [ADDR_W-1:0] dp_addr,
  output logic [1:0]        dp_dir,
  output logic [STN_W-1:0]  dp_station,
  output logic [SLOT_W-1:0] dp_slot,
  output logic [CNT_W-1:0]  dp_index
);

  adm_state_e        state;
  logic [TID_W-1:0]  cur_tid;
  logic [CNT_W-1:0]  cur_cnt;
  logic [STN_W-1:0]  cur_stn;
  logic [SLOT_W-1:0] cur_slot;
  logic [CNT_W-1:0]  pos;
  logic              last_pos;
  logic              is_direct;

  assign nt_ready  = (state == ADM_IDLE);
  assign fs_ready  = (state == ADM_WAIT_SLOT);
  assign dep_ready = (state == ADM_READ_DEP);

  assign last_pos  = (pos == (cur_cnt - CNT_W'(1)));
  assign is_direct = (dep_dir == DIR_DIRECT);

  // Task context doubles as the registered header and tracker fields.
  assign hd_station   = cur_stn;
  assign hd_slot      = cur_slot;
  assign hd_task_id   = cur_tid;
  assign hd_dep_count = cur_cnt;
  assign dp_station   = cur_stn;
  assign dp_slot      = cur_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ADM_IDLE;
      hd_valid <= 1'b0;
      dp_valid <= 1'b0;
      pos      <= '0;
    end else begin
      case (state)
        ADM_IDLE: begin
          if (nt_valid) begin
            state <= ADM_WAIT_SLOT;
          end
        end
        // Parked here until a station offers a slot.
        ADM_WAIT_SLOT: begin
          if (fs_valid) begin
            hd_valid <= 1'b1;
            state    <= ADM_SEND_HDR;
          end
        end
        ADM_SEND_HDR: begin
          if (hd_ready) begin
            hd_valid <= 1'b0;
            pos      <= '0;
            state    <= (cur_cnt == '0) ? ADM_IDLE : ADM_READ_DEP;
          end
        end
        ADM_READ_DEP: begin
          if (dep_valid) begin
            if (is_direct) begin
              // Immediate values own a position but no tracker.
              if (last_pos) begin
                state <= ADM_IDLE;
              end else begin
                pos <= pos + CNT_W'(1);
              end
            end else begin
              dp_valid <= 1'b1;
              state    <= ADM_SEND_DEP;
            end
          end
        end
        ADM_SEND_DEP: begin
          if (dp_ready) begin
            dp_valid <= 1'b0;
            if (last_pos) begin
              state <= ADM_IDLE;
            end else begin
              pos   <= pos + CNT_W'(1);
              state <= ADM_READ_DEP;
            end
          end
        end
        default: state <= ADM_IDLE;
      endcase
    end
  end

  // Context registers: loaded only in the phase that owns them.
  always_ff @(posedge clk) begin
    if (state == ADM_IDLE && nt_valid) begin
      cur_tid <= nt_task_id;
      cur_cnt <= nt_dep_count;
    end
    if (state == ADM_WAIT_SLOT && fs_valid) begin
      cur_stn  <= fs_station;
      cur_slot <= fs_slot;
    end
    if (state == ADM_READ_DEP && dep_valid && !is_direct) begin
      dp_tracker <= dep_trk;
      dp_addr    <= dep_addr;
      dp_dir     <= dep_dir;
      dp_index   <= pos;
    end
  end

endmodule

// File: rtl/tsk_admit_gw.sv
module tsk_admit_gw #(
  parameter int TID_W         = 16,
  parameter int ADDR_W        = 32,
  parameter int ALIGN_BITS    = 3,
  parameter int NUM_STN       = 4,
  parameter int NUM_SLOT      = 256,
  parameter int NUM_TRK       = 4,
  parameter int MAX_DEPS      = 15,
  parameter bit HASH_FOLD_XOR = 1'b1,
  localparam int STN_W        = $clog2(NUM_STN),
  localparam int SLOT_W       = $clog2(NUM_SLOT),
  localparam int TRK_W        = $clog2(NUM_TRK),
  localparam int CNT_W        = $clog2(MAX_DEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nt_valid,
  output logic              nt_ready,
  input  logic [TID_W-1:0]  nt_task_id,
  input  logic [CNT_W-1:0]  nt_dep_count,
  input  logic              dep_valid,
  output logic              dep_ready,
  input  logic [ADDR_W-1:0] dep_addr,
  input  logic [1:0]        dep_dir,
  input  logic              fs_valid,
  output logic              fs_ready,
  input  logic [STN_W-1:0]  fs_station,
  input  logic [SLOT_W-1:0] fs_slot,
  output logic              hd_valid,
  input  logic              hd_ready,
  output logic [STN_W-1:0]  hd_station,
  output logic [SLOT_W-1:0] hd_slot,
  output logic [TID_W-1:0]  hd_task_id,
  output logic [CNT_W-1:0]  hd_dep_count,
  output logic              dp_valid,
  input  logic              dp_ready,
  output logic [TRK_W-1:0]  dp_tracker,
  output logic [ADDR_W-1:0] dp_addr,
  output logic [1:0]        dp_dir,
  output logic [STN_W-1:0]  dp_station,
  output logic [SLOT_W-1:0] dp_slot,
  output logic [CNT_W-1:0]  dp_index,
  input  logic              cm_valid,
  output logic              cm_ready,
  input  logic [STN_W-1:0]  cm_station,
  input  logic [SLOT_W-1:0] cm_slot,
  output logic              fo_valid,
  input  logic              fo_ready,
  output logic [STN_W-1:0]  fo_station,
  output logic [SLOT_W-1:0] fo_slot
);

  logic [TRK_W-1:0] dep_trk;

  gw_dep_hash #(
    .ADDR_W    (ADDR_W),
    .ALIGN_BITS(ALIGN_BITS),
    .TRK_W     (TRK_W),
    .FOLD_XOR  (HASH_FOLD_XOR)
  ) hash_i (
    .key(dep_addr[ADDR_W-1:ALIGN_BITS]),
    .trk(dep_trk)
  );

  gw_admit_fsm #(
    .TID_W (TID_W),
    .CNT_W (CNT_W),
    .STN_W (STN_W),
    .SLOT_W(SLOT_W),
    .ADDR_W(ADDR_W),
    .TRK_W (TRK_W)
  ) admit_i (
    .clk         (clk),
    .rst         (rst),
    .nt_valid    (nt_valid),
    .nt_ready    (nt_ready),
    .nt_task_id  (nt_task_id),
    .nt_dep_count(nt_dep_count),
    .dep_valid   (dep_valid),
    .dep_ready   (dep_ready),
    .dep_addr    (dep_addr),
    .dep_dir     (dep_dir),
    .dep_trk     (dep_trk),
    .fs_valid    (fs_valid),
    .fs_ready    (fs_ready),
    .fs_station  (fs_station),
    .fs_slot     (fs_slot),
    .hd_valid    (hd_valid),
    .hd_ready    (hd_ready),
    .hd_station  (hd_station),
    .hd_slot     (hd_slot),
    .hd_task_id  (hd_task_id),
    .hd_dep_count(hd_dep_count),
    .dp_valid    (dp_valid),
    .dp_ready    (dp_ready),
    .dp_tracker  (dp_tracker),
    .dp_addr     (dp_addr),
    .dp_dir      (dp_dir),
    .dp_station  (dp_station),
    .dp_slot     (dp_slot),
    .dp_index    (dp_index)
  );

  gw_cmpl_path #(
    .STN_W (STN_W),
    .SLOT_W(SLOT_W)
  ) cmpl_i (
    .clk       (clk),
    .rst       (rst),
    .cm_valid  (cm_valid),
    .cm_ready  (cm_ready),
    .cm_station(cm_station),
    .cm_slot   (cm_slot),
    .fo_valid  (fo_valid),
    .fo_ready  (fo_ready),
    .fo_station(fo_station),
    .fo_slot   (fo_slot)
  );

endmodule

// File: rtl/gw_chk.sv
module gw_chk #(
  parameter int TID_W  = 16,
  parameter int CNT_W  = 4,
  parameter int STN_W  = 2,
  parameter int SLOT_W = 8,
  parameter int ADDR_W = 32,
  parameter int TRK_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              nt_ready,
  input logic              dep_ready,
  input logic              fs_valid,
  input logic              fs_ready,
  input logic [STN_W-1:0]  fs_station,
  input logic [SLOT_W-1:0] fs_slot,
  input logic              hd_valid,
  input logic              hd_ready,
  input logic [STN_W-1:0]  hd_station,
  input logic [SLOT_W-1:0] hd_slot,
  input logic [TID_W-1:0]  hd_task_id,
  input logic [CNT_W-1:0]  hd_dep_count,
  input logic              dp_valid,
  input logic              dp_ready,
  input logic [TRK_W-1:0]  dp_tracker,
  input logic [ADDR_W-1:0] dp_addr,
  input logic [1:0]        dp_dir,
  input logic [CNT_W-1:0]  dp_index,
  input logic              cm_valid,
  input logic              cm_ready,
  input logic [STN_W-1:0]  cm_station,
  input logic [SLOT_W-1:0] cm_slot,
  input logic              fo_valid,
  input logic              fo_ready,
  input logic [STN_W-1:0]  fo_station,
  input logic [SLOT_W-1:0] fo_slot
);

  // R2
  hdr_from_slot_chk: assert property (@(posedge clk) disable iff (rst)
    fs_valid && fs_ready |=> hd_valid && hd_station == $past(fs_station)
                             && hd_slot == $past(fs_slot));

  // R9
  hdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hd_valid && !hd_ready |=> hd_valid && $stable(hd_station) && $stable(hd_slot)
                              && $stable(hd_task_id) && $stable(hd_dep_count));

  // R9
  dep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dp_valid && !dp_ready |=> dp_valid && $stable(dp_tracker) && $stable(dp_addr)
                              && $stable(dp_dir) && $stable(dp_index));

  // R9
  fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fo_valid && !fo_ready |=> fo_valid && $stable(fo_station) && $stable(fo_slot));

  // R6
  no_direct_chk: assert property (@(posedge clk) disable iff (rst)
    dp_valid |-> dp_dir != 2'b11);

  // R7
  fwd_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    cm_valid && cm_ready |=> fo_valid && fo_station == $past(cm_station)
                             && fo_slot == $past(cm_slot));

  // R8
  cmpl_flow_chk: assert property (@(posedge clk) disable iff (rst)
    !fo_valid || fo_ready |-> cm_ready);

  // R11
  one_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nt_ready, fs_ready, dep_ready}));

  // R12
  dep_after_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    hd_valid |-> !dep_ready);

endmodule

bind tsk_admit_gw gw_chk #(
  .TID_W (TID_W),
  .CNT_W (CNT_W),
  .STN_W (STN_W),
  .SLOT_W(SLOT_W),
  .ADDR_W(ADDR_W),
  .TRK_W (TRK_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .nt_ready    (nt_ready),
  .dep_ready   (dep_ready),
  .fs_valid    (fs_valid),
  .fs_ready    (fs_ready),
  .fs_station  (fs_station),
  .fs_slot     (fs_slot),
  .hd_valid    (hd_valid),
  .hd_ready    (hd_ready),
  .hd_station  (hd_station),
  .hd_slot     (hd_slot),
  .hd_task_id  (hd_task_id),
  .hd_dep_count(hd_dep_count),
  .dp_valid    (dp_valid),
  .dp_ready    (dp_ready),
  .dp_tracker  (dp_tracker),
  .dp_addr     (dp_addr),
  .dp_dir      (dp_dir),
  .dp_index    (dp_index),
  .cm_valid    (cm_valid),
  .cm_ready    (cm_ready),
  .cm_station  (cm_station),
  .cm_slot     (cm_slot),
  .fo_valid    (fo_valid),
  .fo_ready    (fo_ready),
  .fo_station  (fo_station),
  .fo_slot     (fo_slot)
);

// File: tb/tsk_admit_gw_tb_top.sv
module tsk_admit_gw_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        nt_valid = 0, nt_ready;
  logic [15:0] nt_task_id = 0;
  logic [3:0]  nt_dep_count = 0;
  logic        dep_valid = 0, dep_ready;
  logic [31:0] dep_addr = 0;
  logic [1:0]  dep_dir = 0;
  logic        fs_valid = 0, fs_ready;
  logic [1:0]  fs_station = 0;
  logic [7:0]  fs_slot = 0;
  logic        hd_valid, hd_ready = 1;
  logic [1:0]  hd_station;
  logic [7:0]  hd_slot;
  logic [15:0] hd_task_id;
  logic [3:0]  hd_dep_count;
  logic        dp_valid, dp_ready = 1;
  logic [1:0]  dp_tracker, dp_dir, dp_station;
  logic [31:0] dp_addr;
  logic [7:0]  dp_slot;
  logic [3:0]  dp_index;
  logic        cm_valid = 0, cm_ready;
  logic [1:0]  cm_station = 0;
  logic [7:0]  cm_slot = 0;
  logic        fo_valid, fo_ready = 1;
  logic [1:0]  fo_station;
  logic [7:0]  fo_slot;

  tsk_admit_gw dut_i (.*);

  typedef struct packed {
    logic [1:0]  trk;
    logic [31:0] addr;
    logic [1:0]  dir;
    logic [1:0]  stn;
    logic [7:0]  slot;
    logic [3:0]  idx;
  } dpk_t;

  int n_tests = 0, n_fail = 0;
  logic [15:0] tid_q[$];
  logic [3:0]  cnt_q[$];
  logic [31:0] da_q[$];
  logic [1:0]  dd_q[$];
  logic [9:0]  fs_q[$];
  logic [9:0]  cm_q[$];
  dpk_t        exp_dp[$];
  int tasks_sent = 0, hdr_seen = 0, dp_seen = 0, dp_exp_total = 0;
  int cm_sent = 0, cm_seen = 0;
  bit sink_rand = 0;

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // R5: XOR of the 2-bit fields of addr >> 3
  function automatic logic [1:0] exp_trk(logic [31:0] a);
    logic [31:0] s;
    logic [1:0]  h;
    s = a >> 3;
    h = '0;
    for (int i = 0; i < 16; i++) h = h ^ s[2*i +: 2];
    return h;
  endfunction

  // ---------------- header sink ----------------
  bit          hold_pend = 0;
  logic [29:0] hold_snap;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend)  // R9
        chk("R9", "header held", {hd_valid, hd_station, hd_slot, hd_task_id, hd_dep_count},
            {1'b1, hold_snap});
      hd_ready = sink_rand ? ($urandom % 3 != 0) : 1'b1;
      if (hd_valid && hd_ready) begin
        logic [15:0] t;
        logic [3:0]  c;
        logic [9:0]  f;
        hold_pend = 0;
        hdr_seen++;
        if (tid_q.size() == 0 || fs_q.size() == 0) begin
          chk("R2", "unexpected header", 1, 0);
        end else begin
          t = tid_q.pop_front();
          c = cnt_q.pop_front();
          f = fs_q.pop_front();
          chk("R2", "header task id", hd_task_id, t);
          chk("R2", "header dep count", hd_dep_count, c);
          chk("R2", "header station/slot", {hd_station, hd_slot}, f);
          for (int i = 0; i < c; i++) begin
            logic [31:0] a;
            logic [1:0]  d;
            a = da_q.pop_front();
            d = dd_q.pop_front();
            if (d != 2'b11) begin
              exp_dp.push_back('{exp_trk(a), a, d, f[9:8], f[7:0], 4'(i)});
              dp_exp_total++;
            end
          end
        end
      end else if (hd_valid) begin
        hold_pend = 1;
        hold_snap = {hd_station, hd_slot, hd_task_id, hd_dep_count};
      end else begin
        hold_pend = 0;
      end
    end
  end

  // ---------------- tracker packet sink ----------------
  always @(negedge clk) begin
    if (!rst) begin
      dp_ready = sink_rand ? ($urandom % 3 != 0) : 1'b1;
      if (dp_valid && dp_ready) begin
        dpk_t e;
        dp_seen++;
        if (exp_dp.size() == 0) begin
          chk("R6", "unexpected tracker packet", 1, 0);
        end else begin
          e = exp_dp.pop_front();
          chk("R5", "tracker index", dp_tracker, e.trk);
          chk("R4", "address/dir", {dp_addr, dp_dir}, {e.addr, e.dir});
          chk("R4", "station/slot/index", {dp_station, dp_slot, dp_index},
              {e.stn, e.slot, e.idx});
          chk("R6", "no direct code", dp_dir == 2'b11, 0);
        end
      end
    end
  end

  // ---------------- finish notice sink ----------------
  always @(negedge clk) begin
    if (!rst) begin
      fo_ready = sink_rand ? ($urandom % 4 != 0) : 1'b1;
      if (fo_valid && fo_ready) begin
        cm_seen++;
        if (cm_q.size() == 0) chk("R7", "unexpected notice", 1, 0);
        else chk("R7", "forwarded notice", {fo_station, fo_slot}, cm_q.pop_front());
      end
    end
  end

  // ---------------- drivers ----------------
  task automatic send_task(logic [15:0] tid, logic [3:0] cnt,
                           logic [31:0] addrs[16], logic [1:0] dirs[16]);
    tid_q.push_back(tid);
    cnt_q.push_back(cnt);
    for (int i = 0; i < cnt; i++) begin
      da_q.push_back(addrs[i]);
      dd_q.push_back(dirs[i]);
    end
    tasks_sent++;
    @(negedge clk);
    nt_valid = 1; nt_task_id = tid; nt_dep_count = cnt;
    #1;
    while (!nt_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    nt_valid = 0;
    for (int i = 0; i < cnt; i++) begin
      if (i > 0) @(negedge clk);
      dep_valid = 1; dep_addr = addrs[i]; dep_dir = dirs[i];
      #1;
      while (!dep_ready) begin @(negedge clk); #1; end
    end
    if (cnt > 0) begin @(negedge clk); dep_valid = 0; end
  endtask

  task automatic give_slots(int n, bit gaps);
    for (int k = 0; k < n; k++) begin
      if (gaps) repeat ($urandom % 4) @(negedge clk);
      @(negedge clk);
      fs_valid = 1; fs_station = 2'($urandom); fs_slot = 8'($urandom);
      #1;
      while (!fs_ready) begin @(negedge clk); #1; end
      fs_q.push_back({fs_station, fs_slot});
      @(negedge clk);
      fs_valid = 0;
    end
  endtask

  task automatic send_cmpl(int n);
    for (int k = 0; k < n; k++) begin
      if (sink_rand) repeat ($urandom % 3) @(negedge clk);
      @(negedge clk);
      cm_valid = 1; cm_station = 2'($urandom); cm_slot = 8'($urandom);
      #1;
      while (!cm_ready) begin @(negedge clk); #1; end
      cm_q.push_back({cm_station, cm_slot});
      cm_sent++;
      @(negedge clk);
      cm_valid = 0;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] addrs[16];
    logic [1:0]  dirs[16];
    int          dp_before;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    #1;
    // R1, R3, R12: outputs while reset is asserted
    chk("R1", "valids in reset", {hd_valid, dp_valid, fo_valid}, 0);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: first cycle after reset
    chk("R1", "readies after reset", {nt_ready, cm_ready}, 2'b11);
    chk("R3", "fs_ready idle", fs_ready, 0);
    chk("R12", "dep_ready idle", dep_ready, 0);

    // Parked submission: no free slot, completions must keep flowing
    addrs[0] = 32'h0000_1008; dirs[0] = 2'b00;
    addrs[1] = 32'hDEAD_BEEF; dirs[1] = 2'b11;
    addrs[2] = 32'hFFFF_FFF8; dirs[2] = 2'b10;
    fork
      send_task(16'h0011, 4'd3, addrs, dirs);
      begin
        repeat (5) @(negedge clk);
        #1;
        chk("R11", "nt_ready while parked", nt_ready, 0);
        chk("R12", "dep_ready while parked", dep_ready, 0);
        chk("R3", "no header without slot", hd_valid, 0);
        send_cmpl(12);
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "notices through while parked", cm_seen, 12);
        chk("R3", "still no header", hd_valid, 0);
        give_slots(1, 0);
      end
    join
    repeat (4) @(negedge clk);
    #1;
    chk("R11", "nt_ready after task", nt_ready, 1);

    // R10: zero dependencies
    fork
      send_task(16'h0BAD, 4'd0, addrs, dirs);
      give_slots(1, 0);
    join
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "header of zero-dep task seen", hdr_seen, 2);
    chk("R10", "nt_ready back high", nt_ready, 1);

    // R6: fifteen direct values produce no tracker packet
    for (int i = 0; i < 16; i++) begin addrs[i] = $urandom; dirs[i] = 2'b11; end
    dp_before = dp_seen;
    fork
      send_task(16'hC0DE, 4'd15, addrs, dirs);
      give_slots(1, 0);
    join
    repeat (5) @(negedge clk);
    #1;
    chk("R6", "no packets for direct beats", dp_seen, dp_before);
    chk("R6", "nt_ready after direct task", nt_ready, 1);

    // R4/R5: every direction code in one task, alignment-sensitive addresses
    for (int i = 0; i < 15; i++) begin
      addrs[i] = 32'h1 << (i + 3);
      dirs[i]  = 2'(i);
    end
    fork
      send_task(16'h4444, 4'd15, addrs, dirs);
      give_slots(1, 0);
    join

    // Random traffic with back-pressure on every output
    sink_rand = 1;
    fork
      begin
        for (int t = 0; t < 60; t++) begin
          logic [3:0] c;
          c = 4'($urandom % 16);
          for (int i = 0; i < 16; i++) begin addrs[i] = $urandom; dirs[i] = 2'($urandom); end
          send_task(16'($urandom), c, addrs, dirs);
        end
      end
      give_slots(60, 1);
      send_cmpl(150);
    join
    sink_rand = 0;
    repeat (30) @(negedge clk);
    #1;
    chk("R2", "all headers delivered", hdr_seen, tasks_sent);
    chk("R4", "all tracker packets delivered", dp_seen, dp_exp_total);
    chk("R4", "tracker queue drained", exp_dp.size(), 0);
    chk("R7", "all notices delivered", cm_seen, cm_sent);
    chk("R11", "idle at end", {nt_ready, fs_ready, dep_ready}, 3'b100);
    summary();
    $finish;
  end

endmodule